// File: doc/BRIEF.md
# Timed Pattern Output Controller

This block drives a 16-bit output port from a staged copy instead of from direct writes. Software loads a next-data register, a per-bit enable mask and a per-group trigger choice over a small byte-wide register bus. The port is split into four 4-bit groups. Each group listens to one of four single-cycle compare-match pulses that come from timers outside the block. When the selected pulse for a group arrives, the enabled bits of that group copy their staged value into the port register. All other bits keep their value.

Groups are handled in pairs: groups 1/0 form the low byte and groups 3/2 form the high byte. Each pair has a mode bit. In shared layout, the pair's staged data is one byte at one address. In split layout, the two nibbles sit at two addresses, so two pieces of software that drive groups on different timers can update their nibble without a read-modify-write. The port register can also be written directly. A transfer in the same cycle takes priority on the bits it loads.

Top module: `pattern_out_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the port, both enable bytes, the staged data, the trigger selection and the layout mode are all zero. In shared layout, addresses 5 and 7 read 0xFF.
- R2: When group g fires, each port bit of that group whose enable bit is 1 takes its staged value. The value is visible on `port_o` in the cycle after the edge that samples the pulse.
- R3: A port bit whose enable bit is 0, or whose group does not fire, keeps its value unless it is written directly.
- R4: Address 8 holds the trigger selection. Bits [2g+1:2g] pick which `cm_i` bit fires group g. Several groups may pick the same input.
- R5: In shared layout, address 4 reads and writes staged bits 7..0 and address 6 reads and writes staged bits 15..8. Addresses 5 and 7 read 0xFF and ignore writes.
- R6: Address 9 bit 0 sets split layout for groups 1/0, and bit 1 sets it for groups 3/2. In split layout, the upper group's nibble is at bits 7..4 of address 4 (or 6) and the lower group's nibble is at bits 3..0 of address 5 (or 7). The other nibble at each of these addresses reads 0xF and ignores writes.
- R7: If staged data is written in the same cycle as a transfer, the transfer uses the value held before the write, and the new value is stored afterwards.
- R8: Addresses 0 and 1 read and write port bits 7..0 and 15..8. If a transfer loads a bit in the same cycle, the transfer wins for that bit.
- R9: Addresses 2 and 3 are read/write enable masks for port bits 7..0 and 15..8. They change only on a reset or a write. Unused addresses 10..15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe, one byte per cycle |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational from the address |
| cm_i | input | 4 | Compare-match pulses, one cycle wide |
| port_o | output | 16 | Port data register |

## Verification
The assertions assume that `bus_we_i`, `bus_addr_i` and `cm_i` are free of X at every sampled edge, and that `bus_we_i` and `cm_i` are low while reset is held. They also assume that compare matches are one-cycle events: a pulse held high is seen as a fresh trigger on each edge. The bench changes inputs only at falling edges. It holds the write strobe and the pulses at zero during reset, and it draws every pulse and write as a one-cycle event from a seeded generator. The generated traffic includes address values outside the map, to exercise the unused range.

// File: rtl/poc_pkg.sv
// Package: shared sizes and register addresses for the pattern output controller.
// Assumes a byte-wide register bus and 4-bit output groups, paired into bytes.
package poc_pkg;
    localparam int GRP_W   = 4;
    localparam int N_GRP   = 4;
    localparam int PORT_W  = GRP_W * N_GRP;
    localparam int BYTE_W  = 8;
    localparam int N_PAIR  = PORT_W / BYTE_W;
    localparam int N_CM    = 4;
    localparam int SEL_W   = $clog2(N_CM);
    localparam int ADDR_W  = 4;

    localparam logic [ADDR_W-1:0] A_PORT_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PORT_HI  = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_LO    = 4'd2;
    localparam logic [ADDR_W-1:0] A_EN_HI    = 4'd3;
    localparam logic [ADDR_W-1:0] A_STG_LO   = 4'd4;
    localparam logic [ADDR_W-1:0] A_STG_LO_B = 4'd5;
    localparam logic [ADDR_W-1:0] A_STG_HI   = 4'd6;
    localparam logic [ADDR_W-1:0] A_STG_HI_B = 4'd7;
    localparam logic [ADDR_W-1:0] A_TRIG     = 4'd8;
    localparam logic [ADDR_W-1:0] A_LAYOUT   = 4'd9;

    localparam logic [GRP_W-1:0] NIB_ONES = '1;
endpackage

// File: rtl/poc_regs.sv
// Register file: holds the staged data, the enable masks, the trigger selection
// and the layout mode, and decodes the byte bus for reads and writes.
// Assumes one bus access per cycle. Reads are combinational from the address.
module poc_regs
    import poc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [BYTE_W-1:0]        bus_wdata_i,
    input  logic [PORT_W-1:0]        port_i,
    output logic [BYTE_W-1:0]        bus_rdata_o,
    output logic [PORT_W-1:0]        stage_o,
    output logic [PORT_W-1:0]        enable_o,
    output logic [N_GRP*SEL_W-1:0]   trig_sel_o,
    output logic [N_PAIR-1:0]        port_wr_o
);
    logic [PORT_W-1:0]      stage_q;
    logic [PORT_W-1:0]      enable_q;
    logic [N_GRP*SEL_W-1:0] trig_q;
    logic [N_PAIR-1:0]      split_q;

    // Register updates from bus writes. The nibble rules follow the layout mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            enable_q <= '0;
            trig_q   <= '0;
            split_q  <= '0;
        end else if (bus_we_i) begin
            case (bus_addr_i)
                A_EN_LO:    enable_q[7:0]  <= bus_wdata_i;
                A_EN_HI:    enable_q[15:8] <= bus_wdata_i;
                A_STG_LO: begin
                    if (split_q[0]) stage_q[7:4] <= bus_wdata_i[7:4];
                    else            stage_q[7:0] <= bus_wdata_i;
                end
                A_STG_LO_B: begin
                    if (split_q[0]) stage_q[3:0] <= bus_wdata_i[3:0];
                end
                A_STG_HI: begin
                    if (split_q[1]) stage_q[15:12] <= bus_wdata_i[7:4];
                    else            stage_q[15:8]  <= bus_wdata_i;
                end
                A_STG_HI_B: begin
                    if (split_q[1]) stage_q[11:8] <= bus_wdata_i[3:0];
                end
                A_TRIG:     trig_q  <= bus_wdata_i;
                A_LAYOUT:   split_q <= bus_wdata_i[N_PAIR-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer. Reserved nibbles and unused pair addresses read as ones.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_PORT_LO:  bus_rdata_o = port_i[7:0];
            A_PORT_HI:  bus_rdata_o = port_i[15:8];
            A_EN_LO:    bus_rdata_o = enable_q[7:0];
            A_EN_HI:    bus_rdata_o = enable_q[15:8];
            A_STG_LO:   bus_rdata_o = split_q[0] ? {stage_q[7:4], NIB_ONES} : stage_q[7:0];
            A_STG_LO_B: bus_rdata_o = split_q[0] ? {NIB_ONES, stage_q[3:0]} : '1;
            A_STG_HI:   bus_rdata_o = split_q[1] ? {stage_q[15:12], NIB_ONES} : stage_q[15:8];
            A_STG_HI_B: bus_rdata_o = split_q[1] ? {NIB_ONES, stage_q[11:8]} : '1;
            A_TRIG:     bus_rdata_o = trig_q;
            A_LAYOUT:   bus_rdata_o = {{(BYTE_W-N_PAIR){1'b0}}, split_q};
            default:    bus_rdata_o = '0;
        endcase
    end

    // Per-byte write strobes for the port register.
    genvar p;
    generate
        for (p = 0; p < N_PAIR; p++) begin : g_pwr
            assign port_wr_o[p] = bus_we_i && (bus_addr_i == (A_PORT_LO + ADDR_W'(p)));
        end
    endgenerate

    assign stage_o    = stage_q;
    assign enable_o   = enable_q;
    assign trig_sel_o = trig_q;

    // R6
    split_rsvd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split_q[1] && bus_addr_i == A_STG_HI_B) |-> (bus_rdata_o[7:4] == NIB_ONES));

    // R5
    shared_alt_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_q[0] && bus_addr_i == A_STG_LO_B) |-> (bus_rdata_o == 8'hFF));

    // R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_we_i)) |-> $stable(enable_o));
endmodule

// File: rtl/poc_trigger.sv
// Trigger selection: each group picks one of the compare-match inputs.
// Assumes the inputs are one-cycle pulses. A pulse held high fires again on every edge.
module poc_trigger
    import poc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CM-1:0]        cm_i,
    input  logic [N_GRP*SEL_W-1:0] trig_sel_i,
    output logic [N_GRP-1:0]       fire_o
);
    genvar g;
    generate
        for (g = 0; g < N_GRP; g++) begin : g_sel
            // Route the selected compare match to this group.
            assign fire_o[g] = cm_i[trig_sel_i[g*SEL_W +: SEL_W]];
        end
    endgenerate

    // R4
    no_pulse_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_i == '0) |-> (fire_o == '0));
endmodule

// File: rtl/poc_port.sv
// Port data register: loads staged bits on a group trigger under the enable mask.
// Otherwise it takes direct byte writes. A transfer wins over a write on loaded bits.
module poc_port
    import poc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_GRP-1:0]  fire_i,
    input  logic [PORT_W-1:0] enable_i,
    input  logic [PORT_W-1:0] stage_i,
    input  logic [N_PAIR-1:0] port_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [PORT_W-1:0] port_o
);
    logic [PORT_W-1:0] port_q;
    logic [PORT_W-1:0] wr_mask;

    // Expand the byte write strobes into a bit mask.
    always_comb begin
        for (int b = 0; b < PORT_W; b++) wr_mask[b] = port_wr_i[b / BYTE_W];
    end

    // Per-bit update: a transfer first, then a direct write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            for (int b = 0; b < PORT_W; b++) begin
                if (fire_i[b / GRP_W] && enable_i[b]) port_q[b] <= stage_i[b];
                else if (wr_mask[b])                  port_q[b] <= wdata_i[b % BYTE_W];
            end
        end
    end

    assign port_o = port_q;

    // R3
    untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((port_q ^ $past(port_q)) & ~$past(enable_i) & ~$past(wr_mask)) == '0));

    // R2
    enabled_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fire_i[0])) |->
            (((port_q[3:0] ^ $past(stage_i[3:0])) & $past(enable_i[3:0])) == '0));
endmodule

// File: rtl/pattern_out_ctrl.sv
// Timed pattern output controller, top level: connects the register file, the
// trigger selection and the port register. The compare-match sources are outside.
module pattern_out_ctrl
    import poc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [3:0]        bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [3:0]        cm_i,
    output logic [15:0]       port_o
);
    logic [PORT_W-1:0]      stage;
    logic [PORT_W-1:0]      enable;
    logic [N_GRP*SEL_W-1:0] trig_sel;
    logic [N_PAIR-1:0]      port_wr;
    logic [N_GRP-1:0]       fire;
    logic [PORT_W-1:0]      port_q;

    poc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .port_i      (port_q),
        .bus_rdata_o (bus_rdata_o),
        .stage_o     (stage),
        .enable_o    (enable),
        .trig_sel_o  (trig_sel),
        .port_wr_o   (port_wr)
    );

    poc_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cm_i       (cm_i),
        .trig_sel_i (trig_sel),
        .fire_o     (fire)
    );

    poc_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .enable_i  (enable),
        .stage_i   (stage),
        .port_wr_i (port_wr),
        .wdata_i   (bus_wdata_i),
        .port_o    (port_q)
    );

    assign port_o = port_q;
endmodule

// File: tb/sim_pattern_out_ctrl.sv
// Bench: directed corner cases, then seeded random traffic, checked against a model.
module sim_pattern_out_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [3:0] cm = '0;
    logic [7:0] rdata;
    logic [15:0] port;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string prev_tag = "R1";

    // Model state
    logic [15:0] m_port = '0, m_en = '0, m_stg = '0;
    logic [7:0]  m_sel = '0;
    logic [1:0]  m_split = '0;

    always #10 clk = ~clk;

    pattern_out_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cm_i(cm), .port_o(port)
    );

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_port[7:0];
            4'd1: return m_port[15:8];
            4'd2: return m_en[7:0];
            4'd3: return m_en[15:8];
            4'd4: return m_split[0] ? {m_stg[7:4], 4'hF} : m_stg[7:0];
            4'd5: return m_split[0] ? {4'hF, m_stg[3:0]} : 8'hFF;
            4'd6: return m_split[1] ? {m_stg[15:12], 4'hF} : m_stg[15:8];
            4'd7: return m_split[1] ? {4'hF, m_stg[11:8]} : 8'hFF;
            4'd8: return m_sel;
            4'd9: return {6'b0, m_split};
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model by one clock edge with the given inputs.
    task automatic m_step(input logic w, input logic [3:0] a, input logic [7:0] d, input logic [3:0] c);
        logic [15:0] np = m_port;
        for (int b = 0; b < 16; b++) begin
            logic f = c[m_sel[(b/4)*2 +: 2]];
            if (f && m_en[b]) np[b] = m_stg[b];
            else if (w && a == 4'(b/8)) np[b] = d[b%8];
        end
        m_port = np;
        if (w) begin
            case (a)
                4'd2: m_en[7:0] = d;
                4'd3: m_en[15:8] = d;
                4'd4: if (m_split[0]) m_stg[7:4] = d[7:4]; else m_stg[7:0] = d;
                4'd5: if (m_split[0]) m_stg[3:0] = d[3:0];
                4'd6: if (m_split[1]) m_stg[15:12] = d[7:4]; else m_stg[15:8] = d;
                4'd7: if (m_split[1]) m_stg[11:8] = d[3:0];
                4'd8: m_sel = d;
                4'd9: m_split = d[1:0];
                default: ;
            endcase
        end
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: actual %h expected %h", tag, addr, act, exp);
        end
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: check the port result of the previous edge, drive, check the read.
    task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic [3:0] c, input string tag);
        @(negedge clk);
        check16(prev_tag, port, m_port);
        we = w; addr = a; wdata = d; cm = c;
        #1;
        check8(tag, rdata, m_read(a));
        m_step(w, a, d, c);
        prev_tag = tag;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of every address
        for (int a = 0; a < 11; a++) cyc(1'b0, 4'(a), 8'h00, 4'h0, "R1");
        // R9: enable masks
        cyc(1'b1, 4'd2, 8'hFF, 4'h0, "R9");
        cyc(1'b1, 4'd3, 8'h0F, 4'h0, "R9");
        cyc(1'b0, 4'd3, 8'h00, 4'h0, "R9");
        // R5: shared layout staging, alternate addresses ignored
        cyc(1'b1, 4'd4, 8'hA5, 4'h0, "R5");
        cyc(1'b1, 4'd6, 8'h5A, 4'h0, "R5");
        cyc(1'b1, 4'd5, 8'h12, 4'h0, "R5");
        cyc(1'b0, 4'd4, 8'h00, 4'h0, "R5");
        cyc(1'b0, 4'd5, 8'h00, 4'h0, "R5");
        // R2 R3: all groups on cm0; the high byte is half enabled
        cyc(1'b0, 4'd0, 8'h00, 4'h1, "R2 R3");
        cyc(1'b0, 4'd1, 8'h00, 4'h0, "R2 R3");
        // R4: group g on input g (0xE4)
        cyc(1'b1, 4'd8, 8'hE4, 4'h0, "R4");
        cyc(1'b1, 4'd4, 8'h3C, 4'h0, "R4");
        cyc(1'b0, 4'd0, 8'h00, 4'h1, "R4");
        cyc(1'b0, 4'd0, 8'h00, 4'h2, "R4");
        // R7: staged write in the same cycle as the transfer
        cyc(1'b1, 4'd4, 8'hFF, 4'h3, "R7");
        cyc(1'b0, 4'd4, 8'h00, 4'h0, "R7");
        // R8: transfer beats direct write; plain direct write
        cyc(1'b1, 4'd0, 8'h00, 4'h3, "R8");
        cyc(1'b1, 4'd1, 8'hC3, 4'h0, "R8");
        cyc(1'b1, 4'd1, 8'h00, 4'h8, "R8");
        // R6: split layout for both pairs
        cyc(1'b1, 4'd9, 8'h03, 4'h0, "R6");
        cyc(1'b1, 4'd6, 8'h9F, 4'h0, "R6");
        cyc(1'b1, 4'd7, 8'hF6, 4'h0, "R6");
        cyc(1'b1, 4'd4, 8'h70, 4'h0, "R6");
        cyc(1'b1, 4'd5, 8'h0E, 4'h0, "R6");
        for (int a = 4; a < 8; a++) cyc(1'b0, 4'(a), 8'h00, 4'h0, "R6");
        cyc(1'b1, 4'd3, 8'hFF, 4'hC, "R6");
        cyc(1'b0, 4'd1, 8'h00, 4'hC, "R6");
        // Random traffic across the whole map
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] c;
            for (int k = 0; k < 4; k++) c[k] = ($urandom % 4) == 0;
            cyc(1'($urandom % 2), 4'($urandom % 12), 8'($urandom), c, "R2 R3 R4 R5 R6 R7 R8 R9");
        end
        cyc(1'b0, 4'd0, 8'h00, 4'h0, "R2 R3");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule